// File: doc/BRIEF.md
# Split-Byte Access Bridge for Wide Timer Registers

This block lets a CPU with an 8-bit data bus read and write the 16-bit registers of a timer without ever seeing or producing a half-old, half-new value. Two wide registers sit behind it: a free-running counter and a capture register. Both are exposed as a low-byte address and a high-byte address. A single 8-bit holding register, the temp byte, is shared between them and makes each 16-bit transfer atomic.

Software reads the low byte first. That access returns the low byte and, on the same clock edge, copies the matching high byte into the temp byte. The high-byte read that follows returns the temp byte, so the pair always comes from one instant. For a write, software writes the high byte first, which only parks it in the temp byte. The low-byte write then loads all 16 bits in one clock. The capture register accepts writes only when the timer mode uses it as the counter's top value. In every other mode, a hardware capture event copies the counter into it.

The bus side is plain strobes and never applies back-pressure. Every strobe is accepted in the cycle it is presented. Read data appears one cycle later, qualified by a valid pulse, and holds its value until the next read.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the counter, the capture register, the temp byte and the read data are all zero, and the read-valid output is low.
- R2: The read-valid output is high in exactly the cycles that follow a cycle with the read strobe set. The read data changes only in those cycles and holds its value otherwise.
- R3: Address bit 1 selects the register (0 = counter, 1 = capture) and address bit 0 selects the half (0 = low, 1 = high). A low-byte read returns the low byte as it stood before that clock edge. In the same edge it copies that register's pre-edge high byte into the temp byte. A counter increment or capture event in the same cycle does not affect the values returned.
- R4: A high-byte read returns the temp byte as it stood before that edge, never the live high byte of the register.
- R5: A high-byte write to either register, in any mode, stores the write data in the temp byte. When the same access also reads, the write takes precedence for the temp byte.
- R6: A low-byte write to the counter loads {temp byte, write data} in one clock. It takes precedence over an increment in that cycle.
- R7: With its enable high and no low-byte write, the counter adds one per clock and wraps from 0xFFFF to 0. With its enable low it holds.
- R8: When the mode does not use the capture register as top, a capture event copies the pre-edge counter value into it. In modes that do use it as top, capture events have no effect.
- R9: The capture register uses itself as top only in modes 8, 10, 12 and 14 of the 4-bit mode input. Only in those modes does a low-byte write load {temp byte, write data} into it. In all other modes, capture low-byte writes leave it unchanged.
- R10: The temp byte is shared. If a low-byte read of one register is followed by a low-byte read of the other, a subsequent high-byte read returns the second register's high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Byte address: bit 1 register, bit 0 half |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid pulse |
| mode_i | input | 4 | Timer waveform mode |
| cnt_en_i | input | 1 | Counter increment enable |
| cap_evt_i | input | 1 | Hardware capture event |
| cnt_o | output | 16 | Counter value |
| cap_o | output | 16 | Capture register value |

## Verification
The hardest case to reach is a low-byte read of the capture register in the same clock as a capture event. The bridge must return the old pair even though the register changes on that edge. A close second is an interleaving of the two registers between the halves of one access. The directed phase builds both cases with distinct known high bytes. It then checks the bytes returned against the pre-edge values and the new capture value. A long mixed phase follows, where strobes, events, increments and modes change every clock. A behavioural model predicts each output in every cycle.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int REG_CNT = 0;
  localparam int REG_CAP = 1;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
endpackage

// File: rtl/wbr_decode.sv
module wbr_decode #(
  parameter int ADDR_W   = 2,
  parameter int NUM_REGS = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  output logic [NUM_REGS-1:0] wr_lo,
  output logic [NUM_REGS-1:0] rd_lo,
  output logic                wr_hi,
  output logic                rd_hi
);
  import wbr_pkg::*;
  localparam int SEL_W = ADDR_W - 1;

  half_e half;
  logic [SEL_W-1:0] sel;

  assign half  = half_e'(addr[0]);
  assign sel   = addr[ADDR_W-1:1];
  assign wr_hi = wr && (half == HALF_HI);
  assign rd_hi = rd && (half == HALF_HI);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_lo[g] = wr && (half == HALF_LO) && (sel == SEL_W'(g));
    assign rd_lo[g] = rd && (half == HALF_LO) && (sel == SEL_W'(g));
  end
endmodule

// File: rtl/wbr_temp.sv
module wbr_temp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park_en,
  input  logic [DATA_W-1:0] park_data,
  input  logic              latch_en,
  input  logic [DATA_W-1:0] latch_data,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (park_en)  q <= park_data;
    else if (latch_en) q <= latch_data;
  end
endmodule

// File: rtl/wbr_counter.sv
module wbr_counter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_val,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= load_val;
    else if (inc_en)  q <= q + WORD_W'(1);
  end
endmodule

// File: rtl/wbr_capture.sv
module wbr_capture #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [WORD_W-1:0] src,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_val,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= load_val;
    else if (evt)     q <= src;
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 4,
  parameter logic [(1<<MODE_W)-1:0] CAP_TOP_MODES = 16'h5500,
  localparam int WORD_W   = 2 * DATA_W,
  localparam int NUM_REGS = 2,
  localparam int ADDR_W   = 1 + $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cnt_en_i,
  input  logic              cap_evt_i,
  output logic [WORD_W-1:0] cnt_o,
  output logic [WORD_W-1:0] cap_o
);
  import wbr_pkg::*;
  localparam int SEL_W = ADDR_W - 1;

  logic [NUM_REGS-1:0] wr_lo, rd_lo;
  logic                wr_hi, rd_hi;
  logic [DATA_W-1:0]   temp_q;
  logic [WORD_W-1:0]   words [NUM_REGS];
  logic                cap_is_top;
  logic [SEL_W-1:0]    sel;
  logic [DATA_W-1:0]   lo_sel, hi_sel;

  assign cap_is_top = CAP_TOP_MODES[mode_i];
  assign sel        = addr_i[ADDR_W-1:1];
  assign lo_sel     = words[sel][DATA_W-1:0];
  assign hi_sel     = words[sel][WORD_W-1:DATA_W];

  wbr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr(addr_i), .wr(wr_i), .rd(rd_i),
    .wr_lo(wr_lo), .rd_lo(rd_lo), .wr_hi(wr_hi), .rd_hi(rd_hi)
  );

  wbr_temp #(.DATA_W(DATA_W)) u_temp (
    .clk(clk), .rst_n(rst_n),
    .park_en(wr_hi), .park_data(wdata_i),
    .latch_en(|rd_lo), .latch_data(hi_sel),
    .q(temp_q)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    if (g == REG_CNT) begin : g_cnt
      wbr_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_en(cnt_en_i),
        .load_en(wr_lo[g]), .load_val({temp_q, wdata_i}),
        .q(words[g])
      );
    end else begin : g_cap
      wbr_capture #(.WORD_W(WORD_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .evt(cap_evt_i && !cap_is_top), .src(words[REG_CNT]),
        .load_en(wr_lo[g] && cap_is_top), .load_val({temp_q, wdata_i}),
        .q(words[g])
      );
    end
  end

  assign cnt_o = words[REG_CNT];
  assign cap_o = words[REG_CAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_hi)      rdata_o <= temp_q;
      else if (rd_i)  rdata_o <= lo_sel;
    end
  end
endmodule

// File: rtl/wbr_checker.sv
module wbr_checker #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 4,
  parameter logic [(1<<MODE_W)-1:0] CAP_TOP_MODES = 16'h5500,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rd_valid_o,
  input logic [MODE_W-1:0] mode_i,
  input logic              cnt_en_i,
  input logic              cap_evt_i,
  input logic [WORD_W-1:0] cnt_o,
  input logic [WORD_W-1:0] cap_o,
  input logic [DATA_W-1:0] temp_q
);
  logic top, wr_cnt_lo, wr_cap_lo, rd_cnt_lo, rd_cap_lo;
  assign top       = CAP_TOP_MODES[mode_i];
  assign wr_cnt_lo = wr_i && addr_i == ADDR_W'(0);
  assign wr_cap_lo = wr_i && addr_i == ADDR_W'(2);
  assign rd_cnt_lo = rd_i && addr_i == ADDR_W'(0);
  assign rd_cap_lo = rd_i && addr_i == ADDR_W'(2);

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n) rd_i |=> rd_valid_o);
  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n) !rd_i |=> !rd_valid_o);
  a_r2_data_holds: assert property (@(posedge clk) disable iff (!rst_n) !rd_i |=> $stable(rdata_o));
  a_r3_cnt_lo_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_lo |=> rdata_o == $past(cnt_o[DATA_W-1:0]));
  a_r3_cap_lo_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap_lo |=> rdata_o == $past(cap_o[DATA_W-1:0]));
  a_r3_cnt_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_lo |=> temp_q == $past(cnt_o[WORD_W-1:DATA_W]));
  a_r10_cap_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap_lo |=> temp_q == $past(cap_o[WORD_W-1:DATA_W]));
  a_r4_hi_read_temp: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i[0]) |=> rdata_o == $past(temp_q));
  a_r5_hi_write_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i[0]) |=> temp_q == $past(wdata_i));
  a_r6_cnt_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_lo |=> cnt_o == {$past(temp_q), $past(wdata_i)});
  a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt_lo && cnt_en_i) |=> cnt_o == $past(cnt_o) + WORD_W'(1));
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt_lo && !cnt_en_i) |=> $stable(cnt_o));
  a_r8_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt_i && !top) |=> cap_o == $past(cnt_o));
  a_r8_top_ignores_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (top && !wr_cap_lo) |=> $stable(cap_o));
  a_r9_cap_write_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cap_lo && top) |=> cap_o == {$past(temp_q), $past(wdata_i)});
  a_r9_cap_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cap_lo && !top && !cap_evt_i) |=> $stable(cap_o));
endmodule

bind wide_reg_bridge wbr_checker #(
  .DATA_W(DATA_W), .MODE_W(MODE_W), .CAP_TOP_MODES(CAP_TOP_MODES),
  .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .rd_valid_o(rd_valid_o),
  .mode_i(mode_i), .cnt_en_i(cnt_en_i), .cap_evt_i(cap_evt_i),
  .cnt_o(cnt_o), .cap_o(cap_o), .temp_q(temp_q)
);

// File: tb/tb_wide_reg_bridge.sv
module tb_wide_reg_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, en = 1'b0, evt = 1'b0;
  logic [7:0] wdata = '0;
  logic [3:0] mode = '0;
  logic [7:0] rdata;
  logic rvalid;
  logic [15:0] cnt, cap;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wide_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rvalid), .mode_i(mode),
    .cnt_en_i(en), .cap_evt_i(evt), .cnt_o(cnt), .cap_o(cap)
  );

  // behavioural reference model
  logic [15:0] m_cnt = '0, m_cap = '0;
  logic [7:0]  m_tmp = '0, m_rd = '0;
  logic        m_rv = 1'b0;
  always @(posedge clk) begin
    logic [15:0] c0, p0, sel;
    logic [7:0] t0;
    logic top;
    if (!rst_n) begin
      m_cnt = '0; m_cap = '0; m_tmp = '0; m_rd = '0; m_rv = 1'b0;
    end else begin
      c0 = m_cnt; p0 = m_cap; t0 = m_tmp;
      top = (mode == 8) || (mode == 10) || (mode == 12) || (mode == 14);
      sel = addr[1] ? p0 : c0;
      m_rv = rd;
      if (rd) m_rd = addr[0] ? t0 : sel[7:0];
      if (wr && addr[0]) m_tmp = wdata;
      else if (rd && !addr[0]) m_tmp = sel[15:8];
      if (wr && addr == 2'd0) m_cnt = {t0, wdata};
      else if (en) m_cnt = c0 + 16'd1;
      if (wr && addr == 2'd2 && top) m_cap = {t0, wdata};
      else if (evt && !top) m_cap = c0;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R7 counter vs model", cnt, m_cnt);
    chk("R8 capture vs model", cap, m_cap);
    chk("R2 valid vs model", {15'd0, rvalid}, {15'd0, m_rv});
    chk("R3 rdata vs model", {8'd0, rdata}, {8'd0, m_rd});
  end

  task automatic cyc(input logic r, input logic w, input logic [1:0] a,
                     input logic [7:0] d, input logic e);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    #1;
    rd = 1'b0; wr = 1'b0; evt = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 cnt reset", cnt, 16'h0);
    chk("R1 cap reset", cap, 16'h0);
    chk("R1 valid reset", {15'd0, rvalid}, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R5/R6 counter write pair
    cyc(0, 1, 2'd1, 8'hAB, 0);
    cyc(0, 1, 2'd0, 8'hCD, 0);
    chk("R6 counter commit", cnt, 16'hABCD);
    cyc(1, 0, 2'd1, 8'h00, 0);
    chk("R5 parked byte via hi read", {8'd0, rdata}, 16'h00AB);
    chk("R2 valid after read", {15'd0, rvalid}, 16'h1);
    cyc(0, 0, 2'd0, 8'h00, 0);
    chk("R2 valid drops", {15'd0, rvalid}, 16'h0);

    // R9 gated capture write
    mode = 4'd0;
    cyc(0, 1, 2'd3, 8'h12, 0);
    cyc(0, 1, 2'd2, 8'h34, 0);
    chk("R9 capture write ignored", cap, 16'h0000);
    mode = 4'd8;
    cyc(0, 1, 2'd3, 8'h12, 0);
    cyc(0, 1, 2'd2, 8'h34, 0);
    chk("R9 capture write in top mode", cap, 16'h1234);

    // R8 event ignored in top mode
    cyc(0, 0, 2'd0, 8'h00, 1);
    chk("R8 event ignored in top mode", cap, 16'h1234);

    // R4 high read returns latched, not live
    mode = 4'd0; en = 1'b1;
    cyc(1, 0, 2'd0, 8'h00, 0);
    chk("R3 lo read pre-increment", {8'd0, rdata}, 16'h00CD);
    for (int i = 0; i < 60; i++) cyc(0, 0, 2'd0, 8'h00, 0);
    chk("R7 counter advanced", cnt, 16'hABCD + 16'd61);
    cyc(1, 0, 2'd1, 8'h00, 0);
    chk("R4 hi read returns latched byte", {8'd0, rdata}, 16'h00AB);

    // R8 capture copies pre-edge counter
    snap = cnt;
    cyc(0, 0, 2'd0, 8'h00, 1);
    chk("R8 capture copies counter", cap, snap);

    // R3 low read coinciding with capture event
    snap = cap;
    cyc(1, 0, 2'd2, 8'h00, 1);
    chk("R3 lo read returns old capture", {8'd0, rdata}, {8'd0, snap[7:0]});
    cyc(1, 0, 2'd3, 8'h00, 0);
    chk("R3 hi read returns old capture", {8'd0, rdata}, {8'd0, snap[15:8]});

    // R10 shared temp corruption
    en = 1'b0;
    cyc(0, 1, 2'd1, 8'h5A, 0); cyc(0, 1, 2'd0, 8'h01, 0);
    mode = 4'd10;
    cyc(0, 1, 2'd3, 8'hC3, 0); cyc(0, 1, 2'd2, 8'h02, 0);
    cyc(1, 0, 2'd0, 8'h00, 0);
    cyc(1, 0, 2'd2, 8'h00, 0);
    cyc(1, 0, 2'd1, 8'h00, 0);
    chk("R10 hi read gives other register", {8'd0, rdata}, 16'h00C3);

    // R7 wrap
    mode = 4'd0;
    cyc(0, 1, 2'd1, 8'hFF, 0); cyc(0, 1, 2'd0, 8'hFF, 0);
    en = 1'b1;
    cyc(0, 0, 2'd0, 8'h00, 0);
    chk("R7 counter wraps", cnt, 16'h0000);

    // mixed random phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 16) == 0) mode = 4'($urandom % 16);
      en = (($urandom % 10) < 7);
      cyc(($urandom % 10) < 3, ($urandom % 10) < 3, 2'($urandom % 4),
          8'($urandom), ($urandom % 5) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule